// File: doc/BRIEF.md
# Character LCD Init and Write Sequencer

This block drives a parallel character display that is only ever written, never read. When reset is released, it sends a fixed set of four setup instructions. It then waits in an idle state. After that, every rising edge on the request input writes one 8-bit character to the display. The block produces the enable strobe and the register-select line. It also drives the shared 8-bit bus, which carries either an instruction code or the character. The instruction code is expanded from a 2-bit command index.

Every transfer has three phases. First, select and bus are set up while the strobe is low. Next, the strobe is raised for a programmable number of clocks. Finally, the strobe is dropped while select and bus are held for one more clock. A fixed settle wait follows each transfer, so the display's busy flag is never polled. The wait after the clear instruction has its own, longer setting. A request that arrives while the block is busy is held until the block is free. A request that stays high produces only one write.

Top module: `lcd_chr_seq`

## Requirements
- R1: The read/write line `lcd_rw` is 0 in every cycle.
- R2: `lcd_rs` is 1 while a character is on the bus and 0 while an instruction is on the bus. Exactly one source drives the bus during a transfer. When `busy` is 0, `lcd_bus` is 0, `lcd_rs` is 0 and `lcd_e` is 0.
- R3: `lcd_bus` and `lcd_rs` hold the same value from one clock before `lcd_e` rises until the first clock after `lcd_e` falls. `lcd_e` stays high for exactly `E_HIGH_CYC` clocks.
- R4: After reset, four instructions are sent in command-index order. Index 0 is clear display 0x01, index 1 is function set 0x33, index 2 is display on 0x0C and index 3 is entry mode 0x06.
- R5: Take the clock in which `lcd_e` falls and the clock in which the next back-to-back transfer raises it. These are `CLR_SETTLE_CYC`+2 clocks apart after the clear instruction and `SETTLE_CYC`+2 clocks apart after any other transfer.
- R6: A rising edge on `wr_req` writes the `wr_char` value present at that clock edge. All 256 codes are passed through unchanged.
- R7: A `wr_req` held high for many clocks produces exactly one character write.
- R8: A request made during initialization is written right after the fourth instruction's settle wait, with the R5 spacing.
- R9: A request made during a character transfer is written right after that transfer's settle wait, with the R5 spacing.
- R10: `busy` is 1 from reset until initialization finishes. It is also 1 from the clock after a request until that character's settle wait ends, and it is 0 in idle.
- R11: While reset is asserted, `lcd_e`=0, `lcd_rs`=0, `lcd_bus`=0 and `busy`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_req | input | 1 | Character write request, edge detected |
| wr_char | input | DATA_W | Character code captured on a request edge |
| lcd_e | output | 1 | Display enable strobe, latched by the display on its falling edge |
| lcd_rs | output | 1 | Register select: 1 for character, 0 for instruction |
| lcd_rw | output | 1 | Read/write select, held at 0 |
| lcd_bus | output | DATA_W | Shared instruction/character bus |
| busy | output | 1 | High while initializing or transferring |

## Verification
The bench builds the block with `E_HIGH_CYC`=2, `SETTLE_CYC`=3 and `CLR_SETTLE_CYC`=7. With these values the whole power-on sequence takes a few dozen clocks. The longer wait after clear can still be told apart from the normal wait, so every strobe width and gap can be checked to the exact clock. The short settle time makes it cheap to write all 256 character codes. It also leaves room for requests that land during initialization or in the middle of a character transfer.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  // Transfer phases of the sequencer
  typedef enum logic [2:0] {
    PH_BOOT,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_SETTLE,
    PH_IDLE
  } phase_t;

  // Command index; the order is the power-on order
  typedef enum logic [1:0] {
    CI_CLEAR = 2'd0,
    CI_FUNC  = 2'd1,
    CI_DISP  = 2'd2,
    CI_ENTRY = 2'd3
  } cmd_idx_t;

  localparam logic [7:0] CODE_CLEAR = 8'h01;
  localparam logic [7:0] CODE_FUNC  = 8'h33;
  localparam logic [7:0] CODE_DISP  = 8'h0C;
  localparam logic [7:0] CODE_ENTRY = 8'h06;

endpackage

// File: rtl/lcd_cmd_expand.sv
module lcd_cmd_expand
  import lcd_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              en,
  input  cmd_idx_t          idx,
  output logic [DATA_W-1:0] code
);

  logic [7:0] raw;

  always_comb begin
    unique case (idx)
      CI_CLEAR: raw = CODE_CLEAR;
      CI_FUNC:  raw = CODE_FUNC;
      CI_DISP:  raw = CODE_DISP;
      default:  raw = CODE_ENTRY;
    endcase
  end

  // Output is forced to zero when this source does not own the bus
  assign code = en ? DATA_W'(raw) : '0;

endmodule

// File: rtl/lcd_bus_steer.sv
module lcd_bus_steer #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              cmd_en,
  input  logic              chr_en,
  input  logic [DATA_W-1:0] cmd_code,
  input  logic [DATA_W-1:0] chr_code,
  output logic [DATA_W-1:0] bus
);

  // AND-OR steering per bit; an idle bus reads as zero
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign bus[b] = (cmd_en & cmd_code[b]) | (chr_en & chr_code[b]);
  end

endmodule

// File: rtl/lcd_seq_fsm.sv
module lcd_seq_fsm
  import lcd_seq_pkg::*;
#(
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned E_HIGH_CYC     = 12,
  parameter int unsigned SETTLE_CYC     = 2000,
  parameter int unsigned CLR_SETTLE_CYC = 80000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_char,
  output logic              lcd_e,
  output logic              rs,
  output logic              cmd_en,
  output logic              chr_en,
  output cmd_idx_t          cmd_idx,
  output logic [DATA_W-1:0] chr_data,
  output logic              busy
);

  localparam int unsigned MAX_AB  = (E_HIGH_CYC > SETTLE_CYC) ? E_HIGH_CYC : SETTLE_CYC;
  localparam int unsigned CNT_MAX = (MAX_AB > CLR_SETTLE_CYC) ? MAX_AB : CLR_SETTLE_CYC;
  localparam int unsigned CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);

  phase_t            phase_q, phase_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  cmd_idx_t          idx_q, idx_n;
  logic              is_chr_q, is_chr_n;
  logic              pend_q, pend_n;
  logic              req_d_q;
  logic [DATA_W-1:0] pend_chr_q, xfer_chr_q;
  logic              pend_chr_ld, xfer_chr_ld;
  logic [DATA_W-1:0] xfer_chr_src;
  logic              rise;
  logic              start_chr;
  logic              in_xfer;

  assign rise = wr_req & ~req_d_q;

  // Next-state logic
  always_comb begin
    phase_n   = phase_q;
    cnt_n     = cnt_q;
    idx_n     = idx_q;
    is_chr_n  = is_chr_q;
    start_chr = 1'b0;
    unique case (phase_q)
      PH_BOOT: begin
        phase_n  = PH_SETUP;
        idx_n    = CI_CLEAR;
        is_chr_n = 1'b0;
      end
      PH_SETUP: begin
        phase_n = PH_STROBE;
        cnt_n   = CNT_W'(E_HIGH_CYC - 1);
      end
      PH_STROBE: begin
        if (cnt_q == '0) phase_n = PH_HOLD;
        else             cnt_n   = cnt_q - 1'b1;
      end
      PH_HOLD: begin
        phase_n = PH_SETTLE;
        if (!is_chr_q && idx_q == CI_CLEAR) cnt_n = CNT_W'(CLR_SETTLE_CYC - 1);
        else                                cnt_n = CNT_W'(SETTLE_CYC - 1);
      end
      PH_SETTLE: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - 1'b1;
        end else if (!is_chr_q && idx_q != CI_ENTRY) begin
          idx_n   = cmd_idx_t'(idx_q + 1'b1);
          phase_n = PH_SETUP;
        end else if (pend_q || rise) begin
          start_chr = 1'b1;
        end else begin
          phase_n = PH_IDLE;
        end
      end
      PH_IDLE: begin
        if (rise) start_chr = 1'b1;
      end
      default: phase_n = PH_BOOT;
    endcase
    if (start_chr) begin
      phase_n  = PH_SETUP;
      is_chr_n = 1'b1;
    end
  end

  // Pending request bookkeeping: latest edge wins, start consumes it
  always_comb begin
    pend_n       = pend_q;
    pend_chr_ld  = 1'b0;
    xfer_chr_ld  = start_chr;
    xfer_chr_src = rise ? wr_char : pend_chr_q;
    if (start_chr) begin
      pend_n = 1'b0;
    end else if (rise) begin
      pend_n      = 1'b1;
      pend_chr_ld = 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_BOOT;
      cnt_q    <= '0;
      idx_q    <= CI_CLEAR;
      is_chr_q <= 1'b0;
      pend_q   <= 1'b0;
      req_d_q  <= 1'b0;
    end else begin
      phase_q  <= phase_n;
      cnt_q    <= cnt_n;
      idx_q    <= idx_n;
      is_chr_q <= is_chr_n;
      pend_q   <= pend_n;
      req_d_q  <= wr_req;
    end
  end

  // Data registers with explicit load enables, no reset
  always_ff @(posedge clk) begin
    if (pend_chr_ld) pend_chr_q <= wr_char;
    if (xfer_chr_ld) xfer_chr_q <= xfer_chr_src;
  end

  assign in_xfer  = (phase_q == PH_SETUP) || (phase_q == PH_STROBE) || (phase_q == PH_HOLD);
  assign lcd_e    = (phase_q == PH_STROBE);
  assign rs       = in_xfer & is_chr_q;
  assign cmd_en   = in_xfer & ~is_chr_q;
  assign chr_en   = in_xfer & is_chr_q;
  assign cmd_idx  = idx_q;
  assign chr_data = xfer_chr_q;
  assign busy     = (phase_q != PH_IDLE);

  AST_IDLE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> !pend_q); // R9

  AST_CHR_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    is_chr_q |-> (idx_q == CI_ENTRY)); // R8

endmodule

// File: rtl/lcd_chr_seq.sv
module lcd_chr_seq
  import lcd_seq_pkg::*;
#(
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned E_HIGH_CYC     = 12,
  parameter int unsigned SETTLE_CYC     = 2000,
  parameter int unsigned CLR_SETTLE_CYC = 80000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_char,
  output logic              lcd_e,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic [DATA_W-1:0] lcd_bus,
  output logic              busy
);

  logic              cmd_en;
  logic              chr_en;
  cmd_idx_t          cmd_idx;
  logic [DATA_W-1:0] chr_data;
  logic [DATA_W-1:0] cmd_code;
  logic [DATA_W-1:0] chr_code;

  lcd_seq_fsm #(
    .DATA_W         (DATA_W),
    .E_HIGH_CYC     (E_HIGH_CYC),
    .SETTLE_CYC     (SETTLE_CYC),
    .CLR_SETTLE_CYC (CLR_SETTLE_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .wr_char  (wr_char),
    .lcd_e    (lcd_e),
    .rs       (lcd_rs),
    .cmd_en   (cmd_en),
    .chr_en   (chr_en),
    .cmd_idx  (cmd_idx),
    .chr_data (chr_data),
    .busy     (busy)
  );

  lcd_cmd_expand #(.DATA_W(DATA_W)) u_cmd (
    .en   (cmd_en),
    .idx  (cmd_idx),
    .code (cmd_code)
  );

  assign chr_code = chr_en ? chr_data : '0;

  lcd_bus_steer #(.DATA_W(DATA_W)) u_steer (
    .cmd_en   (cmd_en),
    .chr_en   (chr_en),
    .cmd_code (cmd_code),
    .chr_code (chr_code),
    .bus      (lcd_bus)
  );

  assign lcd_rw = 1'b0;

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_en, chr_en})); // R2

  AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_e) |-> ($stable(lcd_bus) && $stable(lcd_rs))); // R3

  AST_FALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> ($stable(lcd_bus) && $stable(lcd_rs))); // R3

  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e |-> busy); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!lcd_e && !lcd_rs && lcd_bus == '0)); // R2

endmodule

// File: tb/sim_lcd_chr_seq.sv
`timescale 1ns/100ps
module sim_lcd_chr_seq;

  localparam int EH  = 2;
  localparam int WT  = 3;
  localparam int CWT = 7;

  logic       clk;
  logic       rst_n;
  logic       wr_req;
  logic [7:0] wr_char;
  logic       lcd_e, lcd_rs, lcd_rw, busy;
  logic [7:0] lcd_bus;

  int vec, misc;

  lcd_chr_seq #(
    .DATA_W(8), .E_HIGH_CYC(EH), .SETTLE_CYC(WT), .CLR_SETTLE_CYC(CWT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_char(wr_char),
    .lcd_e(lcd_e), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_bus(lcd_bus), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Display-side monitor: records each latched transfer
  logic [7:0] ev_bus [0:511];
  logic       ev_rs  [0:511];
  int         ev_rise[0:511];
  int         ev_fall[0:511];
  int         ev_n;
  int         sidx;
  int         rw_bad, stab_bad, idle_bad, ebusy_bad;
  logic       p_e, p_rs;
  logic [7:0] p_bus;
  int         cur_rise;

  initial begin
    ev_n = 0; sidx = 0; rw_bad = 0; stab_bad = 0; idle_bad = 0; ebusy_bad = 0;
    p_e = 0; p_rs = 0; p_bus = 0; cur_rise = 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      sidx = sidx + 1;
      if (lcd_rw !== 1'b0) rw_bad = rw_bad + 1;
      if (!busy && (lcd_bus !== 8'h00 || lcd_rs !== 1'b0 || lcd_e !== 1'b0)) idle_bad = idle_bad + 1;
      if (lcd_e && !busy) ebusy_bad = ebusy_bad + 1;
      if (lcd_e || p_e) begin
        if (lcd_bus !== p_bus || lcd_rs !== p_rs) stab_bad = stab_bad + 1;
      end
      if (lcd_e && !p_e) cur_rise = sidx;
      if (!lcd_e && p_e && ev_n < 512) begin
        ev_bus[ev_n]  = lcd_bus;
        ev_rs[ev_n]   = lcd_rs;
        ev_rise[ev_n] = cur_rise;
        ev_fall[ev_n] = sidx;
        ev_n = ev_n + 1;
      end
      p_e = lcd_e; p_rs = lcd_rs; p_bus = lcd_bus;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vec = vec + 1;
    if (act != exp) begin
      misc = misc + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_ev(input int target);
    for (int i = 0; i < 3000 && ev_n < target; i++) step();
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) step();
  endtask

  task automatic pulse_req(input logic [7:0] c);
    wr_char = c;
    wr_req  = 1'b1;
    step();
    wr_req  = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, misc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=done");
    vec = vec + 1;
    misc = misc + 1;
    summary();
    $finish;
  end

  initial begin
    int base;
    vec = 0; misc = 0;
    rst_n = 1'b0; wr_req = 1'b0; wr_char = 8'h00;
    repeat (3) step();
    // R11 reset state
    chk("R11 e in reset", int'(lcd_e), 0);
    chk("R11 rs in reset", int'(lcd_rs), 0);
    chk("R11 bus in reset", int'(lcd_bus), 0);
    chk("R11 busy in reset", int'(busy), 1);
    rst_n = 1'b1;
    step();
    step();
    chk("R10 busy during init", int'(busy), 1);

    // R8/R7: request during init, held for many clocks; data changes after the edge
    wr_char = 8'h41;
    wr_req  = 1'b1;
    step();
    step();
    wr_char = 8'h7E;
    repeat (60) step();
    wr_req = 1'b0;
    wait_ev(5);
    repeat (20) step();
    chk("R7 one write for held request", ev_n, 5);

    chk("R4 clear code", int'(ev_bus[0]), 8'h01);
    chk("R4 function code", int'(ev_bus[1]), 8'h33);
    chk("R4 display code", int'(ev_bus[2]), 8'h0C);
    chk("R4 entry code", int'(ev_bus[3]), 8'h06);
    for (int k = 0; k < 4; k++) chk("R2 rs low for instruction", int'(ev_rs[k]), 0);
    chk("R2 rs high for character", int'(ev_rs[4]), 1);
    chk("R6 R8 deferred char value", int'(ev_bus[4]), 8'h41);
    for (int k = 0; k < 5; k++) chk("R3 strobe width", ev_fall[k] - ev_rise[k], EH);
    chk("R5 gap after clear", ev_rise[1] - ev_fall[0], CWT + 2);
    chk("R5 gap after function", ev_rise[2] - ev_fall[1], WT + 2);
    chk("R5 gap after display", ev_rise[3] - ev_fall[2], WT + 2);
    chk("R8 gap init to char", ev_rise[4] - ev_fall[3], WT + 2);
    chk("R10 busy low in idle", int'(busy), 0);
    chk("R2 bus zero in idle", int'(lcd_bus), 0);

    // R6: every character code from idle
    for (int c = 0; c < 256; c++) begin
      wait_idle();
      base = ev_n;
      pulse_req(8'(c));
      if (c == 0) chk("R10 busy after request", int'(busy), 1);
      wait_ev(base + 1);
      chk("R6 char code", int'(ev_bus[base]), c);
      chk("R2 rs for char", int'(ev_rs[base]), 1);
    end

    // R9: request during a character transfer is queued
    wait_idle();
    step();
    base = ev_n;
    pulse_req(8'h55);
    step();
    pulse_req(8'h66);
    wait_ev(base + 2);
    repeat (10) step();
    chk("R9 first char", int'(ev_bus[base]), 8'h55);
    chk("R9 queued char", int'(ev_bus[base + 1]), 8'h66);
    chk("R9 queued gap", ev_rise[base + 1] - ev_fall[base], WT + 2);
    chk("R9 no extra write", ev_n, base + 2);
    chk("R10 busy low after queue", int'(busy), 0);

    chk("R1 rw low all cycles", rw_bad, 0);
    chk("R3 bus and rs stable around strobe", stab_bad, 0);
    chk("R2 quiet bus in idle", idle_bad, 0);
    chk("R10 strobe only while busy", ebusy_bad, 0);

    summary();
    $finish;
  end

endmodule